// File: doc/BRIEF.md
# Doubleword Load Address Generator

This block carries out one kind of instruction: a load of a 64-bit doubleword into a pair of 32-bit registers. It takes a 32-bit instruction word and decodes the base register, the offset source and the addressing mode. It forms the memory address and issues a read on a 64-bit memory port whose data arrives one cycle later. It then writes that data into an even/odd destination pair. Modes that modify the base also write the updated base back.

The block holds two 32-entry register files, called side A and side B. One selector bit picks the side that supplies the base and the offset register. A second, independent bit picks the side that receives the loaded pair. A maintenance port lets the surrounding logic preload and inspect any register. Conditional execution and hazards between back-to-back instructions are handled outside this block.

Top module: `dwl_load_unit`

## Requirements
- R1: After reset, every register on both sides reads 0, and `mem_req` and `err_illegal` are both low.
- R2: An instruction is legal only when bit 8 is 1 and bit 23 is 0, and its mode code is a defined one. For any other valid word, `err_illegal` is high in the same cycle, `mem_req` stays low, and no register changes.
- R3: The mode field is bits 12:9. Bit 3 of the code selects base writeback, bit 2 selects a register offset (0 selects the immediate), and bit 0 selects add (0 selects subtract). Bit 1 selects post-modify and is only defined when bit 3 is 1. The codes 0010, 0011, 0110 and 0111 are illegal.
- R4: The offset is the register indexed by bits 17:13, or those five bits zero-extended as an immediate. It is shifted left by 3, and the 32-bit result wraps.
- R5: For the offset-only and pre-modify codes, `mem_addr` equals the base plus or minus the scaled offset. It appears in the same cycle as the instruction.
- R6: For the post-modify codes (1010, 1011, 1110, 1111), `mem_addr` equals the base value before the update.
- R7: For the writeback codes, the base register (bits 22:18) holds the base plus or minus the scaled offset from the next clock edge. For the offset-only codes, the base register is unchanged.
- R8: Bit 7 selects the side that supplies the base and the offset register: 0 selects A and 1 selects B.
- R9: Bit 1 selects the destination side: 0 selects A and 1 selects B. The destination index is bits 27:23. The low 32 bits of `mem_rdata` are sampled in the cycle after `mem_req` and go to the even register; the high 32 bits go to the odd register. The pair is readable two cycles after the request.
- R10: When the destination pair overlaps the updated base on the same side, that register ends up holding the loaded data.
- R11: Registers 0 and 1 of each side are ordinary storage. They can serve as a base or as a destination, and neither is hard-wired.
- R12: The maintenance port writes `dbg_wdata` into the selected register on a clock edge when `dbg_we` is high. `dbg_rdata` shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the doubleword |
| mem_rdata | input | 64 | Read data, valid one cycle after the request |
| err_illegal | output | 1 | Word rejected this cycle |
| dbg_we | input | 1 | Maintenance write enable |
| dbg_side | input | 1 | Maintenance side select, 0 = A, 1 = B |
| dbg_idx | input | 5 | Maintenance register index |
| dbg_wdata | input | 32 | Maintenance write data |
| dbg_rdata | output | 32 | Maintenance read data |

## Verification
A fault in the address path shows up on `mem_addr` in the same cycle as the instruction. A wrong base update only becomes visible when the base register is read back after the next edge, or when a later instruction uses that base. A fault in the capture of the pending load shows up two cycles after the request as a wrong or missing pair on the maintenance port. A fault in side selection or in write priority only surfaces when the bench reads both sides and the overlapping register.

// File: rtl/dwl_pkg.sv
package dwl_pkg;
  typedef struct packed {
    logic ok;
    logic use_reg;
    logic add;
    logic wb;
    logic post;
  } dwl_mode_t;

  function automatic dwl_mode_t decode_mode(input logic [3:0] code);
    dwl_mode_t m;
    m.ok      = code[3] | ~code[1];
    m.use_reg = code[2];
    m.add     = code[0];
    m.wb      = code[3];
    m.post    = code[3] & code[1];
    return m;
  endfunction

  function automatic logic [31:0] scale_dw(input logic [31:0] v);
    return v << 3;
  endfunction

  function automatic logic [31:0] step_base(input logic [31:0] base,
                                            input logic [31:0] sofs,
                                            input logic add);
    return add ? base + sofs : base - sofs;
  endfunction
endpackage

// File: rtl/dwl_decode.sv
module dwl_decode
  import dwl_pkg::*;
(
  input  logic [31:0] instr,
  output logic [4:0]  dst_idx,
  output logic [4:0]  base_idx,
  output logic [4:0]  ofs_field,
  output logic        addr_side,
  output logic        dst_side,
  output dwl_mode_t   mode,
  output logic        legal
);
  assign dst_idx   = instr[27:23];
  assign base_idx  = instr[22:18];
  assign ofs_field = instr[17:13];
  assign addr_side = instr[7];
  assign dst_side  = instr[1];
  assign mode      = decode_mode(instr[12:9]);
  assign legal     = instr[8] & ~instr[23] & mode.ok;
endmodule

// File: rtl/dwl_addr.sv
module dwl_addr
  import dwl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] ofs_reg_val,
  input  logic [4:0]        ofs_imm,
  input  dwl_mode_t         mode,
  output logic [DATA_W-1:0] access_addr,
  output logic [DATA_W-1:0] next_base
);
  logic [DATA_W-1:0] raw_ofs;
  logic [DATA_W-1:0] scaled;

  assign raw_ofs     = mode.use_reg ? ofs_reg_val : DATA_W'(ofs_imm);
  assign scaled      = scale_dw(raw_ofs);
  assign next_base   = step_base(base_val, scaled, mode.add);
  assign access_addr = mode.post ? base_val : next_base;
endmodule

// File: rtl/dwl_regfile.sv
module dwl_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd1_data,
  input  logic [IDX_W-1:0]  rd2_idx,
  output logic [DATA_W-1:0] rd2_data,
  input  logic              ext_we,
  input  logic [IDX_W-1:0]  ext_idx,
  input  logic [DATA_W-1:0] ext_wd,
  input  logic              bw_we,
  input  logic [IDX_W-1:0]  bw_idx,
  input  logic [DATA_W-1:0] bw_wd,
  input  logic              pw_we,
  input  logic [IDX_W-1:0]  pw_idx,
  input  logic [DATA_W-1:0] pw_lo,
  input  logic [DATA_W-1:0] pw_hi
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    logic pair_hit;
    assign pair_hit = pw_we && (pw_idx[IDX_W-1:1] == GI[IDX_W-1:1]);
    always_ff @(posedge clk) begin
      if (!rst_n)                        regs[g] <= '0;
      else if (pair_hit)                 regs[g] <= GI[0] ? pw_hi : pw_lo;
      else if (bw_we && bw_idx == GI)    regs[g] <= bw_wd;
      else if (ext_we && ext_idx == GI)  regs[g] <= ext_wd;
    end
  end

  assign rd0_data = regs[rd0_idx];
  assign rd1_data = regs[rd1_idx];
  assign rd2_data = regs[rd2_idx];

  // R9
  pair_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pw_we |=> regs[{$past(pw_idx[IDX_W-1:1]), 1'b0}] == $past(pw_lo));
  // R9
  pair_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pw_we |=> regs[{$past(pw_idx[IDX_W-1:1]), 1'b1}] == $past(pw_hi));
  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_we && bw_we && pw_idx[IDX_W-1:1] == bw_idx[IDX_W-1:1])
      |=> regs[$past(bw_idx)] == ($past(bw_idx[0]) ? $past(pw_hi) : $past(pw_lo)));
endmodule

// File: rtl/dwl_load_unit.sv
module dwl_load_unit
  import dwl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  localparam int IDX_W  = $clog2(NREG),
  localparam int PAIR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [31:0]       instr,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [PAIR_W-1:0] mem_rdata,
  output logic              err_illegal,
  input  logic              dbg_we,
  input  logic              dbg_side,
  input  logic [IDX_W-1:0]  dbg_idx,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata
);
  logic [4:0]  dst_idx, base_idx, ofs_field;
  logic        addr_side, dst_side, legal, fire;
  dwl_mode_t   mode;
  logic [DATA_W-1:0] base_val, ofs_val, next_base;
  logic [DATA_W-1:0] base_rd [2];
  logic [DATA_W-1:0] ofs_rd  [2];
  logic [DATA_W-1:0] dbg_rd  [2];
  logic              ld_pend, ld_side;
  logic [IDX_W-1:0]  ld_idx;
  logic              base_wb_evt;

  dwl_decode u_dec (
    .instr(instr), .dst_idx(dst_idx), .base_idx(base_idx),
    .ofs_field(ofs_field), .addr_side(addr_side), .dst_side(dst_side),
    .mode(mode), .legal(legal)
  );

  assign fire        = instr_valid & legal;
  assign err_illegal = instr_valid & ~legal;
  assign mem_req     = fire;
  assign base_wb_evt = fire & mode.wb;
  assign base_val    = base_rd[addr_side];
  assign ofs_val     = ofs_rd[addr_side];
  assign dbg_rdata   = dbg_rd[dbg_side];

  dwl_addr #(.DATA_W(DATA_W)) u_addr (
    .base_val(base_val), .ofs_reg_val(ofs_val), .ofs_imm(ofs_field),
    .mode(mode), .access_addr(mem_addr), .next_base(next_base)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    dwl_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .rd0_idx(IDX_W'(base_idx)), .rd0_data(base_rd[s]),
      .rd1_idx(IDX_W'(ofs_field)), .rd1_data(ofs_rd[s]),
      .rd2_idx(dbg_idx), .rd2_data(dbg_rd[s]),
      .ext_we(dbg_we && dbg_side == 1'(s)), .ext_idx(dbg_idx), .ext_wd(dbg_wdata),
      .bw_we(base_wb_evt && addr_side == 1'(s)), .bw_idx(IDX_W'(base_idx)),
      .bw_wd(next_base),
      .pw_we(ld_pend && ld_side == 1'(s)), .pw_idx(ld_idx),
      .pw_lo(mem_rdata[DATA_W-1:0]), .pw_hi(mem_rdata[PAIR_W-1:DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_pend <= 1'b0;
      ld_side <= 1'b0;
      ld_idx  <= '0;
    end else begin
      ld_pend <= fire;
      if (fire) begin
        ld_side <= dst_side;
        ld_idx  <= {IDX_W'(dst_idx[4:1]), 1'b0};
      end
    end
  end

  // R2
  illegal_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |-> !mem_req);
  // R2
  odd_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[23]) |-> err_illegal);
  // R9
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> ld_pend);
  // R5
  align_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && base_val[2:0] == 3'b000) |-> mem_addr[2:0] == 3'b000);
endmodule

// File: tb/tb_dwl_load_unit.sv
module tb_dwl_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic        err_illegal;
  logic        dbg_we = 1'b0;
  logic        dbg_side = 1'b0;
  logic [4:0]  dbg_idx = '0;
  logic [31:0] dbg_wdata = '0;
  logic [31:0] dbg_rdata;
  int total = 0;
  int fails = 0;

  localparam logic [3:0] M_NEG_IMM = 4'b0000, M_POS_IMM = 4'b0001;
  localparam logic [3:0] M_NEG_REG = 4'b0100, M_POS_REG = 4'b0101;
  localparam logic [3:0] M_PREINC_IMM = 4'b1001, M_PREDEC_REG = 4'b1100;
  localparam logic [3:0] M_POSTINC_IMM = 4'b1011, M_POSTDEC_REG = 4'b1110;

  always #5ns clk = ~clk;

  dwl_load_unit dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .err_illegal(err_illegal), .dbg_we(dbg_we), .dbg_side(dbg_side),
    .dbg_idx(dbg_idx), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  function automatic logic [31:0] m_lo(input logic [31:0] a); return a + 32'h11; endfunction
  function automatic logic [31:0] m_hi(input logic [31:0] a); return a ^ 32'hFFFF_0000; endfunction

  always_ff @(posedge clk) mem_rdata <= mem_req ? {m_hi(mem_addr), m_lo(mem_addr)} : 64'h0;

  function automatic logic [31:0] mk(input int dst, input int base, input int ofs,
                                     input logic [3:0] mode, input bit y, input bit s);
    return {3'b000, 1'b0, 5'(dst), 5'(base), 5'(ofs), mode, 1'b1, y, 5'b11001, s, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit side, input int idx, input logic [31:0] v);
    @(negedge clk);
    dbg_we = 1'b1; dbg_side = side; dbg_idx = 5'(idx); dbg_wdata = v;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input bit side, input int idx, input logic [31:0] exp);
    dbg_side = side; dbg_idx = 5'(idx);
    #1;
    chk(tag, dbg_rdata, exp);
  endtask

  task automatic issue(input string tag, input logic [31:0] w, input bit exp_err,
                       input logic [31:0] exp_addr);
    @(negedge clk);
    instr_valid = 1'b1; instr = w;
    #1;
    chk({tag, " err"}, 32'(err_illegal), 32'(exp_err));
    chk({tag, " req"}, 32'(mem_req), 32'(!exp_err));
    if (!exp_err) chk({tag, " addr"}, mem_addr, exp_addr);
    @(negedge clk);
    instr_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 req", 32'(mem_req), 0);
    chk("R1 err", 32'(err_illegal), 0);
    rd_chk("R1 A0", 0, 0, 0);
    rd_chk("R1 B31", 1, 31, 0);
  endtask

  task automatic t_maint();
    wr(1, 31, 32'hDEAD_BEEF);
    rd_chk("R12 B31", 1, 31, 32'hDEAD_BEEF);
    rd_chk("R12 A31", 0, 31, 0);
  endtask

  task automatic t_offset();
    wr(0, 5, 32'h1000); wr(0, 6, 3);
    issue("R5 R4 posimm", mk(10, 5, 4, M_POS_IMM, 0, 0), 0, 32'h1020);
    rd_chk("R7 base kept", 0, 5, 32'h1000);
    rd_chk("R9 even", 0, 10, m_lo(32'h1020));
    rd_chk("R9 odd", 0, 11, m_hi(32'h1020));
    issue("R5 negimm", mk(14, 5, 4, M_NEG_IMM, 0, 0), 0, 32'h0FE0);
    issue("R5 posreg", mk(14, 5, 6, M_POS_REG, 0, 0), 0, 32'h1018);
    issue("R5 negreg", mk(14, 5, 6, M_NEG_REG, 0, 0), 0, 32'h0FE8);
    rd_chk("R9 negreg lo", 0, 14, m_lo(32'h0FE8));
    rd_chk("R7 base kept2", 0, 5, 32'h1000);
  endtask

  task automatic t_pre();
    wr(1, 2, 32'h2000); wr(1, 3, 2);
    issue("R8 preinc", mk(20, 2, 2, M_PREINC_IMM, 1, 1), 0, 32'h2010);
    rd_chk("R7 preinc base", 1, 2, 32'h2010);
    rd_chk("R9 B20", 1, 20, m_lo(32'h2010));
    issue("R8 predec reg", mk(20, 2, 3, M_PREDEC_REG, 1, 1), 0, 32'h2000);
    rd_chk("R7 predec base", 1, 2, 32'h2000);
    rd_chk("R8 A2 untouched", 0, 2, 0);
  endtask

  task automatic t_post();
    wr(0, 7, 32'h3000); wr(0, 8, 1);
    issue("R6 postinc", mk(22, 7, 31, M_POSTINC_IMM, 0, 0), 0, 32'h3000);
    rd_chk("R7 postinc base", 0, 7, 32'h30F8);
    issue("R6 postdec", mk(22, 7, 8, M_POSTDEC_REG, 0, 0), 0, 32'h30F8);
    rd_chk("R7 postdec base", 0, 7, 32'h30F0);
    rd_chk("R9 A23", 0, 23, m_hi(32'h30F8));
  endtask

  task automatic t_side();
    issue("R9 cross", mk(12, 5, 0, M_POS_IMM, 0, 1), 0, 32'h1000);
    rd_chk("R9 B12", 1, 12, m_lo(32'h1000));
    rd_chk("R9 B13", 1, 13, m_hi(32'h1000));
    rd_chk("R9 A12 clean", 0, 12, 0);
  endtask

  task automatic t_wrap();
    wr(0, 9, 32'h2000_0001);
    issue("R4 wrap", mk(24, 5, 9, M_POS_REG, 0, 0), 0, 32'h1008);
  endtask

  task automatic t_illegal();
    logic [31:0] w;
    w = mk(10, 5, 1, M_PREINC_IMM, 0, 0); w[23] = 1'b1;
    issue("R2 odd dst", w, 1, 0);
    rd_chk("R2 base same", 0, 5, 32'h1000);
    w = mk(10, 5, 1, M_PREINC_IMM, 0, 0); w[8] = 1'b0;
    issue("R2 rbit", w, 1, 0);
    issue("R3 bad code", mk(26, 5, 1, 4'b0011, 0, 0), 1, 0);
    issue("R3 bad code2", mk(26, 5, 1, 4'b0110, 0, 0), 1, 0);
    rd_chk("R2 base same2", 0, 5, 32'h1000);
    rd_chk("R2 no load", 0, 26, 0);
  endtask

  task automatic t_r0();
    wr(0, 0, 32'h40);
    issue("R11 base r0", mk(0, 0, 1, M_POS_IMM, 0, 1), 0, 32'h48);
    rd_chk("R11 B0", 1, 0, m_lo(32'h48));
    rd_chk("R11 B1", 1, 1, m_hi(32'h48));
    rd_chk("R11 A0 kept", 0, 0, 32'h40);
  endtask

  task automatic t_overlap();
    wr(0, 4, 32'h4000);
    issue("R10 overlap", mk(4, 4, 1, M_POSTINC_IMM, 0, 0), 0, 32'h4000);
    rd_chk("R10 A4 load wins", 0, 4, m_lo(32'h4000));
    rd_chk("R10 A5", 0, 5, m_hi(32'h4000));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_maint();
    t_offset();
    t_pre();
    t_post();
    t_side();
    t_wrap();
    t_illegal();
    t_r0();
    t_overlap();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule